// File: doc/BRIEF.md
# Serial TDM Loopback Selector

This block builds the transmit serial stream for a T1 trunk on a 2.048 Mbit/s TDM bus. A frame holds 32 timeslots of 8 bits each, sent most significant bit first at one bit per bit clock. A frame pulse marks the first bit of slot 0. The 24 payload channels sit in timeslots 1 to 24. A 2-bit loopback control word chooses what fills those channels. The choices are the system input stream, the received-data input (payload loopback), or a generated line-loopback activate or deactivate code.

The control word is sampled only on the frame pulse, so every frame comes from a single source. The output is registered: the bit on the output in clock n+1 belongs to the bit position of clock n. In every slot outside the payload, the output is held high.

The bus runs at a fixed rate and has no back-pressure. No valid/ready handshake exists, because the sender cannot be stalled. Every clock carries exactly one bit in and one bit out, and the frame pulse is the only qualifier.

Top module: `tdm_loopback_sel`

## Requirements
- R1: While reset is asserted, and in the first frame after it, the output is high and the mode is normal (code 00).
- R2: In normal mode (control code 00), the output bit during a payload bit is the system input bit of the previous clock.
- R3: In payload loopback mode (control code 01), the output bit during a payload bit is the received-data input bit of the previous clock.
- R4: For the bit positions of slot 0 and of slots 25 to 31, the output is 1 in every mode.
- R5: In activate mode (control code 10), the payload bits carry the repeating pattern 0,0,0,0,1. The pattern runs across slot and frame borders and skips non-payload positions.
- R6: In deactivate mode (control code 11), the payload bits carry the repeating pattern 0,0,1 under the same rules as R5.
- R7: A change of the control word between frame pulses has no effect until the next frame pulse samples it.
- R8: When a frame pulse samples a control code that differs from the current mode, the code pattern restarts at its first bit. When the sampled code is the same as the current mode, the pattern continues.
- R9: A frame pulse that arrives at any bit position restarts the frame at slot 0, bit 0. The position counter wraps after 256 bits if no pulse comes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse_i | input | 1 | High for one clock on bit 0 of slot 0 |
| sys_data_i | input | 1 | System transmit stream (normal mode source) |
| rx_data_i | input | 1 | Received data stream (payload loopback source) |
| lb_ctl_i | input | 2 | Loopback control word: 00 normal, 01 payload loopback, 10 activate code, 11 deactivate code |
| tx_data_o | output | 1 | Serial transmit stream, one clock behind the inputs |

## Verification
Two functions can act in the same clock. The mode latch and the code-pattern restart both fire on a frame pulse, and that pulse may arrive early, in the middle of the payload. The bench drives an early pulse together with a new control word in the same clock. It then checks that the new frame starts at slot 0, takes the new source, and starts its code from the first pattern bit. Control-word changes between pulses are also driven, to show that they wait for the next frame.

// File: rtl/tdm_lb_pkg.sv
package tdm_lb_pkg;
  typedef enum logic [1:0] {
    LB_NORMAL  = 2'b00,
    LB_PAYLOAD = 2'b01,
    LB_ACT     = 2'b10,
    LB_DEACT   = 2'b11
  } lb_mode_e;
endpackage

// File: rtl/tdm_lb_timing.sv
module tdm_lb_timing #(
  parameter int SLOT_BITS     = 8,
  parameter int SLOTS         = 32,
  parameter int FIRST_SLOT    = 1,
  parameter int PAYLOAD_SLOTS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fp_i,
  output logic payload_o
);
  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int CW         = $clog2(FRAME_BITS);
  localparam int PAY_LO     = FIRST_SLOT * SLOT_BITS;
  localparam int PAY_HI     = PAY_LO + PAYLOAD_SLOTS * SLOT_BITS - 1;

  logic [CW-1:0] cnt_q, pos;

  always_comb begin
    if (fp_i || cnt_q == CW'(FRAME_BITS - 1)) pos = '0;
    else                                      pos = cnt_q + 1'b1;
  end

  assign payload_o = (pos >= CW'(PAY_LO)) && (pos <= CW'(PAY_HI));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= pos;
  end

  // R9
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_i |=> (cnt_q == '0));
endmodule

// File: rtl/tdm_lb_codegen.sv
module tdm_lb_codegen #(
  parameter int ACT_LEN   = 5,
  parameter int DEACT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic adv_i,
  input  logic deact_i,
  output logic code_o
);
  localparam int MAXL = (ACT_LEN > DEACT_LEN) ? ACT_LEN : DEACT_LEN;
  localparam int PW   = (MAXL > 2) ? $clog2(MAXL) : 1;

  logic [PW-1:0] ph_q, last;

  assign last   = deact_i ? PW'(DEACT_LEN - 1) : PW'(ACT_LEN - 1);
  assign code_o = adv_i && (ph_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n)         ph_q <= '0;
    else if (restart_i) ph_q <= '0;
    else if (adv_i)     ph_q <= (ph_q == last) ? '0 : ph_q + 1'b1;
  end

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |-> (ph_q <= last));

  // R8
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (ph_q == '0));
endmodule

// File: rtl/tdm_lb_mux.sv
module tdm_lb_mux
  import tdm_lb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     payload_i,
  input  lb_mode_e mode_i,
  input  logic     sys_i,
  input  logic     rx_i,
  input  logic     code_i,
  output logic     data_o
);
  logic nxt;

  always_comb begin
    if (!payload_i) nxt = 1'b1;
    else begin
      unique case (mode_i)
        LB_NORMAL:  nxt = sys_i;
        LB_PAYLOAD: nxt = rx_i;
        default:    nxt = code_i;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) data_o <= 1'b1;
    else        data_o <= nxt;
  end
endmodule

// File: rtl/tdm_loopback_sel.sv
module tdm_loopback_sel
  import tdm_lb_pkg::*;
#(
  parameter int SLOT_BITS     = 8,
  parameter int SLOTS         = 32,
  parameter int FIRST_SLOT    = 1,
  parameter int PAYLOAD_SLOTS = 24,
  parameter int ACT_LEN       = 5,
  parameter int DEACT_LEN     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_pulse_i,
  input  logic       sys_data_i,
  input  logic       rx_data_i,
  input  logic [1:0] lb_ctl_i,
  output logic       tx_data_o
);
  lb_mode_e mode_q, ctl;
  logic     payload, restart, code_bit;

  assign ctl     = lb_mode_e'(lb_ctl_i);
  assign restart = frame_pulse_i && (ctl != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n)             mode_q <= LB_NORMAL;
    else if (frame_pulse_i) mode_q <= ctl;
  end

  tdm_lb_timing #(
    .SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS),
    .FIRST_SLOT(FIRST_SLOT), .PAYLOAD_SLOTS(PAYLOAD_SLOTS)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .fp_i(frame_pulse_i), .payload_o(payload)
  );

  tdm_lb_codegen #(.ACT_LEN(ACT_LEN), .DEACT_LEN(DEACT_LEN)) u_code (
    .clk(clk), .rst_n(rst_n), .restart_i(restart),
    .adv_i(payload && mode_q[1]), .deact_i(mode_q == LB_DEACT),
    .code_o(code_bit)
  );

  tdm_lb_mux u_mux (
    .clk(clk), .rst_n(rst_n), .payload_i(payload), .mode_i(mode_q),
    .sys_i(sys_data_i), .rx_i(rx_data_i), .code_i(code_bit),
    .data_o(tx_data_o)
  );

  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !payload |=> tx_data_o);

  // R2
  normal_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (payload && mode_q == LB_NORMAL) |=> (tx_data_o == $past(sys_data_i)));

  // R3
  loop_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (payload && mode_q == LB_PAYLOAD) |=> (tx_data_o == $past(rx_data_i)));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_pulse_i |=> $stable(mode_q));
endmodule

// File: tb/tdm_loopback_sel_bench.sv
module tdm_loopback_sel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fp = 1'b0, d0 = 1'b0, d1 = 1'b0;
  logic [1:0] ctl = 2'b00;
  logic       dout;

  int    n_tests = 0, n_fail = 0;
  bit    exp_q[$];
  string tag_q[$];
  string note = "";

  int m_mode = 0, m_phase = 0, m_pos = 0;

  always #4 clk = ~clk;

  tdm_loopback_sel u_tdm_loopback_sel (
    .clk(clk), .rst_n(rst_n), .frame_pulse_i(fp), .sys_data_i(d0),
    .rx_data_i(d1), .lb_ctl_i(ctl), .tx_data_o(dout)
  );

  // driver: one bit per call, pushes the expected output of the next clock
  task automatic drive_bit(input bit f, input logic [1:0] c);
    bit    pay, e;
    int    len;
    string t;
    @(negedge clk);
    fp = f; ctl = c; d0 = 1'($urandom); d1 = 1'($urandom);
    if (f) begin
      m_pos = 0;
      if (int'(c) != m_mode) m_phase = 0;   // R8
    end else m_pos = (m_pos + 1) % 256;     // R9 wrap
    pay = (m_pos >= 8) && (m_pos < 200);
    if (!pay) begin e = 1'b1; t = "R4"; end
    else if (m_mode == 0) begin e = d0; t = "R2"; end
    else if (m_mode == 1) begin e = d1; t = "R3"; end
    else begin
      len = (m_mode == 3) ? 3 : 5;
      e = (m_phase == len - 1);
      m_phase = (m_phase + 1) % len;
      t = (m_mode == 3) ? "R6" : "R5";
    end
    if (f) m_mode = int'(c);                // R7: latched only on the pulse
    exp_q.push_back(e);
    tag_q.push_back({t, note});
  endtask

  task automatic run_frame(input logic [1:0] c, input int nbits,
                           input int chg_at, input logic [1:0] c2);
    for (int i = 0; i < nbits; i++)
      drive_bit(i == 0, (chg_at >= 0 && i >= chg_at) ? c2 : c);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        bit e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        n_tests++;
        if (dout !== e) begin
          n_fail++;
          $display("FAIL %s: tx_data_o=%0b expected %0b", t, dout, e);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not end, got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      d0 = 1'($urandom); ctl = 2'b10;
      n_tests++;
      if (dout !== 1'b1) begin
        n_fail++;
        $display("FAIL R1: tx_data_o=%0b expected 1 in reset", dout);
      end
    end
    ctl = 2'b00;
    rst_n = 1'b1;
    note = "/R1";
    run_frame(2'b00, 256, -1, 2'b00);       // R1 first frame, normal
    note = "";
    run_frame(2'b00, 256, -1, 2'b00);       // R2
    run_frame(2'b01, 256, -1, 2'b01);       // R3
    run_frame(2'b10, 256, -1, 2'b10);       // R5
    run_frame(2'b10, 256, -1, 2'b10);       // R5 continues across frames
    run_frame(2'b11, 256, -1, 2'b11);       // R6, R8 restart
    note = "/R7";
    run_frame(2'b11, 256, 60, 2'b01);       // R7 mid-frame change ignored
    run_frame(2'b01, 256, 100, 2'b10);      // R7
    note = "/R9";
    run_frame(2'b10, 100, -1, 2'b10);       // R8 restart, R9 early pulse
    run_frame(2'b10, 137, -1, 2'b10);       // same mode: phase continues
    run_frame(2'b11, 90, -1, 2'b11);        // early pulse with new code
    run_frame(2'b00, 300, -1, 2'b00);       // R9 wrap without pulse
    note = "";
    run_frame(2'b11, 256, -1, 2'b11);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule